// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

The block sits beside the command bus of a four-bank SDRAM and watches it passively. It decodes the command strobes on each clock edge and keeps track of which banks hold an open row, which are still closing, and how many clocks have gone by since the activates, writes, precharges and refreshes that limit what may legally come next. When a command breaks a spacing or state rule, the block raises a one-cycle flag with a code that names the rule.

Every timing limit is a parameter counted in clocks, and so is the burst length. A controller team drops the block into a simulation or an emulation build next to the memory interface and watches the flag. Data, mode register fields other than the burst length, and analog timing are not examined.

Top module: `sdram_timing_monitor`

## Requirements
- R1: A command is taken at a rising edge when `cke` is high and `csN` is low, and is decoded from {`rasN`,`casN`,`weN`]: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode register set, 110 burst stop, 111 no operation. With `csN` high the strobes are ignored, whatever their values.
- R2: The outcome of the command taken at an edge is visible after that same edge. `violation` is high for one cycle and `violCode` is nonzero, otherwise both are 0. The codes are 1 command during refresh wait, 2 interrupted auto-precharge burst, 3 bank still closing, 4 refresh or mode set with a bank not idle, 5 activate to an open bank, 6 same-bank activate spacing, 7 cross-bank activate spacing, 8 access to a closed bank, 9 access too early after activate, 10 precharge too early after write. When several rules break at once, the lowest code is reported.
- R3: While `cke` is low, commands are ignored and change no bank state. The clock counters keep running.
- R4: An activate to a bank that is already open gives code 5. A read or write to a bank that is not open gives code 8.
- R5: A read or write issued fewer than T_RCD clocks after the activate of that bank gives code 9.
- R6: An activate fewer than T_RC clocks after the previous activate of the same bank gives code 6. An activate fewer than T_RRD clocks after an activate of any other bank gives code 7.
- R7: A precharge with `a10` high closes every open bank. With `a10` low it closes only bank `ba`. A closed bank stays busy for T_RP clocks. During that time an activate, read, write or precharge that addresses it gives code 3.
- R8: A refresh or mode register set while any bank is open or closing gives code 4. Any command other than no operation or deselect fewer than T_RC clocks after a refresh gives code 1.
- R9: A precharge that addresses a bank fewer than BURST_LEN-1+T_WR clocks after a write without auto-precharge to that bank gives code 10.
- R10: A read or write with `a10` high closes its bank. The bank is then busy until BURST_LEN+T_RP clocks after a read, or BURST_LEN-1+T_WR+T_RP clocks after a write. An earlier command to the bank gives code 3.
- R11: During the BURST_LEN-1 clocks after a read or write with auto-precharge, a precharge that addresses that bank, or any burst stop, gives code 2. A read or write to another open bank is legal in that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable of the memory, low means commands are ignored |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Address bit 10: all-bank precharge or auto-precharge select |
| violation | output | 1 | One-cycle flag for a broken rule |
| violCode | output | 4 | Code of the broken rule, 0 when clean |

## Verification
The directed scenarios place commands exactly at and around each spacing limit. For example, a read at two clocks after its activate must flag, and one at three clocks must not. A design whose counter is one off would flag a legal command or miss an early one. Other scenarios check state: an all-bank precharge against a single-bank one, and commands sent with chip select high or clock enable low that must leave an open bank still open. A decoder that ignored those gates would close the bank, and the following read would wrongly report code 8. Finally, the bench breaks several rules at once to check the priority order. It also checks the two auto-precharge windows: a design that reloaded the wrong busy time, or took a burst stop as legal, would report the wrong code or none.

// File: rtl/sdtm_pkg.sv
package sdtm_pkg;

  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  // Strobes from the control to the counter datapath, valid for one cycle.
  typedef struct packed {
    logic                 doAct;
    logic                 doRd;
    logic                 doWr;
    logic                 doPre;
    logic                 doRef;
    logic                 autoPre;
    logic [NUM_BANKS-1:0] bankSel;    // addressed banks (all ones for precharge-all)
    logic [NUM_BANKS-1:0] closeMask;  // banks an explicit precharge actually closes
  } strobe_t;

  // Lower value wins when several rules break together.
  typedef enum logic [3:0] {
    V_NONE      = 4'd0,
    V_REF_WAIT  = 4'd1,
    V_AP_BREAK  = 4'd2,
    V_BUSY      = 4'd3,
    V_NOT_IDLE  = 4'd4,
    V_ACT_OPEN  = 4'd5,
    V_RC        = 4'd6,
    V_RRD       = 4'd7,
    V_CLOSED    = 4'd8,
    V_RCD       = 4'd9,
    V_WR_RECOV  = 4'd10
  } viol_e;

endpackage

// File: rtl/sdtm_counters.sv
module sdtm_counters
  import sdtm_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 8,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  output logic [NUM_BANKS-1:0] rcdBusy,
  output logic [NUM_BANKS-1:0] rcBusy,
  output logic [NUM_BANKS-1:0] idleBusy,
  output logic [NUM_BANKS-1:0] wrBusy,
  output logic [NUM_BANKS-1:0] apBusy,
  output logic                 rrdBusy,
  output logic                 refBusy
);

  // A counter loaded with T-1 at a command edge reads zero again T edges later.
  localparam int MAX_T = BURST_LEN + T_WR + T_RP + T_RC;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] LD_RCD   = CW'(T_RCD - 1);
  localparam logic [CW-1:0] LD_RC    = CW'(T_RC - 1);
  localparam logic [CW-1:0] LD_RRD   = CW'(T_RRD - 1);
  localparam logic [CW-1:0] LD_RP    = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_WR    = CW'(BURST_LEN + T_WR - 2);
  localparam logic [CW-1:0] LD_AP    = CW'(BURST_LEN - 1);
  localparam logic [CW-1:0] LD_RD_AP = CW'(BURST_LEN + T_RP - 1);
  localparam logic [CW-1:0] LD_WR_AP = CW'(BURST_LEN + T_WR + T_RP - 2);

  logic [CW-1:0] rrdCnt, refCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdCnt <= '0;
      refCnt <= '0;
    end else begin
      rrdCnt <= stb.doAct ? LD_RRD : ((rrdCnt != '0) ? rrdCnt - 1'b1 : rrdCnt);
      refCnt <= stb.doRef ? LD_RC  : ((refCnt != '0) ? refCnt - 1'b1 : refCnt);
    end
  end

  assign rrdBusy = (rrdCnt != '0);
  assign refBusy = (refCnt != '0);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] rcdCnt, rcCnt, idleCnt, wrCnt, apCnt;
    logic          hit, access;

    assign hit    = stb.bankSel[b];
    assign access = (stb.doRd | stb.doWr) & hit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rcdCnt  <= '0;
        rcCnt   <= '0;
        idleCnt <= '0;
        wrCnt   <= '0;
        apCnt   <= '0;
      end else begin
        if (stb.doAct && hit) begin
          rcdCnt <= LD_RCD;
          rcCnt  <= LD_RC;
        end else begin
          rcdCnt <= (rcdCnt != '0) ? rcdCnt - 1'b1 : rcdCnt;
          rcCnt  <= (rcCnt  != '0) ? rcCnt  - 1'b1 : rcCnt;
        end

        if (stb.doPre && stb.closeMask[b])
          idleCnt <= LD_RP;
        else if (access && stb.autoPre)
          idleCnt <= stb.doRd ? LD_RD_AP : LD_WR_AP;
        else
          idleCnt <= (idleCnt != '0) ? idleCnt - 1'b1 : idleCnt;

        if (stb.doWr && hit && !stb.autoPre)
          wrCnt <= LD_WR;
        else
          wrCnt <= (wrCnt != '0) ? wrCnt - 1'b1 : wrCnt;

        if (access && stb.autoPre)
          apCnt <= LD_AP;
        else
          apCnt <= (apCnt != '0) ? apCnt - 1'b1 : apCnt;
      end
    end

    assign rcdBusy[b]  = (rcdCnt  != '0);
    assign rcBusy[b]   = (rcCnt   != '0);
    assign idleBusy[b] = (idleCnt != '0);
    assign wrBusy[b]   = (wrCnt   != '0);
    assign apBusy[b]   = (apCnt   != '0);
  end

endmodule

// File: rtl/sdtm_control.sv
module sdtm_control
  import sdtm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BANK_W-1:0]    ba,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] rcdBusy,
  input  logic [NUM_BANKS-1:0] rcBusy,
  input  logic [NUM_BANKS-1:0] idleBusy,
  input  logic [NUM_BANKS-1:0] wrBusy,
  input  logic [NUM_BANKS-1:0] apBusy,
  input  logic                 rrdBusy,
  input  logic                 refBusy,
  output strobe_t              stb,
  output logic                 violation,
  output logic [3:0]           violCode
);

  logic                 taken;
  logic                 isAct, isRd, isWr, isPre, isRef, isMrs, isBst, isAccess, anyCmd;
  logic [NUM_BANKS-1:0] bankOh, sel, bankOpen;
  viol_e                code;

  assign taken = cke & ~csN;

  always_comb begin
    {isAct, isRd, isWr, isPre, isRef, isMrs, isBst} = '0;
    if (taken) begin
      unique case ({rasN, casN, weN})
        3'b011:  isAct = 1'b1;
        3'b101:  isRd  = 1'b1;
        3'b100:  isWr  = 1'b1;
        3'b010:  isPre = 1'b1;
        3'b001:  isRef = 1'b1;
        3'b000:  isMrs = 1'b1;
        3'b110:  isBst = 1'b1;
        default: ;
      endcase
    end
  end

  assign isAccess = isRd | isWr;
  assign anyCmd   = isAct | isAccess | isPre | isRef | isMrs | isBst;
  assign bankOh   = NUM_BANKS'(1) << ba;
  assign sel      = (isPre && a10) ? '1 : bankOh;

  always_comb begin
    stb           = '0;
    stb.doAct     = isAct;
    stb.doRd      = isRd;
    stb.doWr      = isWr;
    stb.doPre     = isPre;
    stb.doRef     = isRef;
    stb.autoPre   = isAccess & a10;
    stb.bankSel   = sel;
    stb.closeMask = sel & bankOpen;
  end

  always_comb begin
    if (refBusy && anyCmd)
      code = V_REF_WAIT;
    else if ((isPre && |(sel & apBusy)) || (isBst && |apBusy))
      code = V_AP_BREAK;
    else if ((isAct || isAccess || isPre) && |(sel & idleBusy))
      code = V_BUSY;
    else if ((isRef || isMrs) && (|bankOpen || |idleBusy))
      code = V_NOT_IDLE;
    else if (isAct && |(sel & bankOpen))
      code = V_ACT_OPEN;
    else if (isAct && |(sel & rcBusy))
      code = V_RC;
    else if (isAct && rrdBusy)
      code = V_RRD;
    else if (isAccess && !(|(sel & bankOpen)))
      code = V_CLOSED;
    else if (isAccess && |(sel & rcdBusy))
      code = V_RCD;
    else if (isPre && |(sel & wrBusy))
      code = V_WR_RECOV;
    else
      code = V_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankOpen  <= '0;
      violation <= 1'b0;
      violCode  <= '0;
    end else begin
      if (isAct)
        bankOpen <= bankOpen | sel;
      else if (isPre || (isAccess && a10))
        bankOpen <= bankOpen & ~sel;
      violation <= (code != V_NONE);
      violCode  <= code;
    end
  end

endmodule

// File: rtl/sdram_timing_monitor.sv
module sdram_timing_monitor
  import sdtm_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 8,
  parameter int T_RP      = 3,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cke,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic [1:0]  ba,
  input  logic        a10,
  output logic        violation,
  output logic [3:0]  violCode
);

  strobe_t              stb;
  logic [NUM_BANKS-1:0] rcdBusy, rcBusy, idleBusy, wrBusy, apBusy;
  logic                 rrdBusy, refBusy;

  sdtm_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .ba       (ba),
    .a10      (a10),
    .rcdBusy  (rcdBusy),
    .rcBusy   (rcBusy),
    .idleBusy (idleBusy),
    .wrBusy   (wrBusy),
    .apBusy   (apBusy),
    .rrdBusy  (rrdBusy),
    .refBusy  (refBusy),
    .stb      (stb),
    .violation(violation),
    .violCode (violCode)
  );

  sdtm_counters #(
    .T_RCD    (T_RCD),
    .T_RRD    (T_RRD),
    .T_RC     (T_RC),
    .T_RP     (T_RP),
    .T_WR     (T_WR),
    .BURST_LEN(BURST_LEN)
  ) i_counters (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rcdBusy (rcdBusy),
    .rcBusy  (rcBusy),
    .idleBusy(idleBusy),
    .wrBusy  (wrBusy),
    .apBusy  (apBusy),
    .rrdBusy (rrdBusy),
    .refBusy (refBusy)
  );

endmodule

// File: rtl/sdram_timing_monitor_sva.sv
module sdram_timing_monitor_sva #(
  parameter int T_RCD = 3,
  parameter int T_RRD = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic [1:0] ba,
  input logic       a10,
  input logic       violation,
  input logic [3:0] violCode
);

  logic pastValid;
  logic isAct, isAccess, isRefMrs;

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assign isAct    = cke && !csN && ({rasN, casN, weN} == 3'b011);
  assign isAccess = cke && !csN && rasN && !casN;
  assign isRefMrs = cke && !csN && !rasN && !casN;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !violation);  // R1
  AST_FLAG_HAS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    violation |-> (violCode != 4'd0));  // R2
  AST_CLEAN_NO_CODE: assert property (@(posedge clk) disable iff (!rstN)
    !violation |-> (violCode == 4'd0));  // R2
  AST_CKE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> !violation);  // R3
  AST_RCD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (T_RCD > 1) && isAccess && $past(isAct) && (ba == $past(ba))) |=> violation);  // R5
  AST_RRD_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (T_RRD > 1) && isAct && $past(isAct) && (ba != $past(ba))) |=> violation);  // R6
  AST_REF_AFTER_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && isRefMrs && $past(isAct)) |=> violation);  // R8

endmodule

bind sdram_timing_monitor sdram_timing_monitor_sva #(
  .T_RCD(T_RCD),
  .T_RRD(T_RRD)
) i_sdram_timing_monitor_sva (
  .clk      (clk),
  .rstN     (rstN),
  .cke      (cke),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .ba       (ba),
  .a10      (a10),
  .violation(violation),
  .violCode (violCode)
);

// File: tb/test_sdram_timing_monitor.sv
`timescale 1ns/100ps
module test_sdram_timing_monitor;

  // Strobe patterns {ras,cas,we}, active low.
  localparam logic [2:0] C_ACT = 3'b011;
  localparam logic [2:0] C_RD  = 3'b101;
  localparam logic [2:0] C_WR  = 3'b100;
  localparam logic [2:0] C_PRE = 3'b010;
  localparam logic [2:0] C_REF = 3'b001;
  localparam logic [2:0] C_MRS = 3'b000;
  localparam logic [2:0] C_BST = 3'b110;
  localparam logic [2:0] C_NOP = 3'b111;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cke = 1'b1;
  logic       csN = 1'b0;
  logic       rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       a10 = 1'b0;
  logic       violation;
  logic [3:0] violCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sdram_timing_monitor i_sdram_timing_monitor (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .a10(a10), .violation(violation), .violCode(violCode)
  );

  task automatic expectCode(input int exp, input string tag);
    checks++;
    if (violation !== (exp != 0) || violCode !== 4'(exp)) begin
      fails++;
      $display("FAIL %s: violation=%0b code=%0d, expected violation=%0b code=%0d",
               tag, violation, violCode, (exp != 0), exp);
    end
  endtask

  task automatic setNop();
    csN = 1'b0; cke = 1'b1; {rasN, casN, weN} = C_NOP; ba = 2'd0; a10 = 1'b0;
  endtask

  task automatic doReset();
    setNop();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic nop(input int n);
    setNop();
    repeat (n) @(negedge clk);
  endtask

  // Drive one command for one edge, then check the outcome of that edge.
  task automatic raw(input logic csV, input logic ckeV, input logic [2:0] rcw,
                     input int bank, input logic a10V, input int exp, input string tag);
    csN = csV; cke = ckeV; {rasN, casN, weN} = rcw; ba = 2'(bank); a10 = a10V;
    @(negedge clk);
    expectCode(exp, tag);
    setNop();
  endtask

  task automatic cmd(input logic [2:0] rcw, input int bank, input logic a10V,
                     input int exp, input string tag);
    raw(1'b0, 1'b1, rcw, bank, a10V, exp, tag);
  endtask

  task automatic tReset();
    doReset();
    expectCode(0, "R2 reset state");
  endtask

  task automatic tDeselect();
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R1 activate");
    nop(2);
    raw(1'b1, 1'b1, C_PRE, 0, 1'b1, 0, "R1 deselected precharge");
    cmd(C_RD, 0, 1'b0, 0, "R1 bank still open");
    cmd(C_BST, 0, 1'b0, 0, "R1 plain burst stop");
  endtask

  task automatic tCkeLow();
    doReset();
    cmd(C_ACT, 1, 1'b0, 0, "R3 activate");
    raw(1'b0, 1'b0, C_PRE, 1, 1'b0, 0, "R3 precharge with cke low");
    raw(1'b0, 1'b0, C_ACT, 1, 1'b0, 0, "R3 activate with cke low");
    cmd(C_RD, 1, 1'b0, 0, "R3 bank untouched");
  endtask

  task automatic tOpenClosed();
    doReset();
    cmd(C_RD, 1, 1'b0, 8, "R4 read idle bank");
    cmd(C_ACT, 0, 1'b0, 0, "R4 activate");
    nop(2);
    cmd(C_ACT, 0, 1'b0, 5, "R4 R2 reopen wins over spacing");
  endtask

  task automatic tRcd();
    doReset();
    cmd(C_ACT, 1, 1'b0, 0, "R5 activate");
    nop(1);
    cmd(C_RD, 1, 1'b0, 9, "R5 read at 2 clocks");
    cmd(C_WR, 1, 1'b0, 0, "R5 write at 3 clocks");
  endtask

  task automatic tActSpacing();
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R6 activate");
    cmd(C_PRE, 0, 1'b0, 0, "R6 precharge");
    nop(2);
    cmd(C_ACT, 0, 1'b0, 6, "R6 same bank too soon");
    cmd(C_ACT, 1, 1'b0, 7, "R6 other bank at 1 clock");
    nop(1);
    cmd(C_ACT, 2, 1'b0, 0, "R6 other bank at 2 clocks");
  endtask

  task automatic tPrecharge();
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R7 activate bank0");
    nop(1);
    cmd(C_ACT, 1, 1'b0, 0, "R7 activate bank1");
    cmd(C_PRE, 2, 1'b1, 0, "R7 precharge all");
    cmd(C_RD, 0, 1'b0, 3, "R7 read closing bank");
    nop(2);
    cmd(C_RD, 1, 1'b0, 8, "R7 bank1 closed by precharge all");
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R7 activate bank0");
    nop(1);
    cmd(C_ACT, 2, 1'b0, 0, "R7 activate bank2");
    nop(2);
    cmd(C_PRE, 0, 1'b0, 0, "R7 single precharge");
    cmd(C_RD, 2, 1'b0, 0, "R7 bank2 stays open");
    cmd(C_RD, 0, 1'b0, 3, "R7 bank0 still closing");
  endtask

  task automatic tRefresh();
    doReset();
    cmd(C_ACT, 1, 1'b0, 0, "R8 activate");
    cmd(C_REF, 0, 1'b0, 4, "R8 refresh with open bank");
    doReset();
    cmd(C_REF, 0, 1'b0, 0, "R8 refresh all idle");
    nop(1);
    cmd(C_MRS, 0, 1'b0, 1, "R8 command during refresh wait");
    nop(5);
    cmd(C_ACT, 3, 1'b0, 0, "R8 activate after wait");
    cmd(C_MRS, 0, 1'b0, 4, "R8 mode set with open bank");
  endtask

  task automatic tWriteRecovery();
    doReset();
    cmd(C_ACT, 2, 1'b0, 0, "R9 activate");
    nop(2);
    cmd(C_WR, 2, 1'b0, 0, "R9 write");
    nop(3);
    cmd(C_PRE, 2, 1'b0, 10, "R9 precharge at 4 clocks");
    doReset();
    cmd(C_ACT, 2, 1'b0, 0, "R9 activate");
    nop(2);
    cmd(C_WR, 2, 1'b0, 0, "R9 write");
    nop(4);
    cmd(C_PRE, 2, 1'b1, 0, "R9 precharge all at 5 clocks");
  endtask

  task automatic tAutoClose();
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R10 activate");
    nop(2);
    cmd(C_WR, 0, 1'b1, 0, "R10 write auto-precharge");
    nop(6);
    cmd(C_ACT, 0, 1'b0, 3, "R10 activate at 7 after write");
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R10 activate");
    nop(2);
    cmd(C_RD, 0, 1'b1, 0, "R10 read auto-precharge");
    nop(6);
    cmd(C_ACT, 0, 1'b0, 0, "R10 activate at 7 after read");
  endtask

  task automatic tApBreak();
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R11 activate bank0");
    nop(1);
    cmd(C_ACT, 1, 1'b0, 0, "R11 activate bank1");
    nop(2);
    cmd(C_RD, 0, 1'b1, 0, "R11 read auto-precharge");
    cmd(C_RD, 1, 1'b0, 0, "R11 other bank interrupts");
    cmd(C_PRE, 0, 1'b0, 2, "R11 precharge during burst");
    doReset();
    cmd(C_ACT, 0, 1'b0, 0, "R11 activate");
    nop(2);
    cmd(C_WR, 0, 1'b1, 0, "R11 write auto-precharge");
    cmd(C_BST, 0, 1'b0, 2, "R11 burst stop during burst");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    tReset();
    tDeselect();
    tCkeLow();
    tOpenClosed();
    tRcd();
    tActSpacing();
    tPrecharge();
    tRefresh();
    tWriteRecovery();
    tAutoClose();
    tApBreak();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

endmodule